// File: doc/BRIEF.md
# Split Load Queue Dispatch Steering

This block sits at load dispatch in an out-of-order core whose load queue is split in two: a small associative queue that searches and is searched by stores, and a larger non-associative FIFO for loads predicted to be independent of in-flight stores. Each cycle it takes at most one dispatched load and its dependence prediction bit and picks its home. Independent loads go to the FIFO, and spill into the associative queue when the FIFO is full. Dependent loads go to the associative queue and stall dispatch when that queue is full. They are never placed in the FIFO.

The FIFO keeps, per entry, the load tag, the address and data written at issue, and an issued flag. Loads retire in order through a commit port. A load in the FIFO never looks into the store queue. When a committing store hits in the external counting filter, the block walks the FIFO from its oldest entry, reading one slot per bank per cycle, and compares each issued entry's address with the store address. The first match raises a one-cycle squash that carries that load's tag. A walk with no match does nothing. During a walk, only entries already checked may commit, and further filter hits are dropped. A flush moves the FIFO tail back to a given pointer and trims or ends any walk in progress.

Top module: `split_lq_steer`

## Requirements
- R1: With dispatch valid and the prediction bit 0 (independent), while the FIFO holds fewer than DEPTH entries and no flush is asserted, the load is steered to the FIFO. `disp_slot` equals the current `tail_ptr`, which then advances by one. Pointers are {wrap bit, index}, and the index returns to 0 after DEPTH-1.
- R2: An independent load that finds the FIFO full goes to the associative queue when `aq_count` < AQ_DEPTH. If the associative queue is also full, it stalls. At most one of `disp_to_fifo`, `disp_to_assoc` and `disp_stall` is high.
- R3: A load with the prediction bit 1 (dependent) goes to the associative queue when `aq_count` < AQ_DEPTH and stalls otherwise. It never goes to the FIFO and never changes `fifo_count`.
- R4: Commit retires the head entry in order. `cmt_ok` is high only if `cmt_valid` is high, the FIFO is not empty, the head has issued and no flush is asserted. `cmt_tag` and `cmt_data` are the tag given at dispatch and the data given at issue.
- R5: A filter hit with a non-empty FIFO and no walk running starts a walk over the entries present. The first issued entry, oldest first, whose address equals the hit address causes `squash_valid` to go high for exactly one cycle with that entry's tag, and the walk ends. A walk that finds no match never raises `squash_valid`.
- R6: The walk checks up to BANKS consecutive entries per cycle. A match in group g (g = 0 is the oldest BANKS entries) shows `squash_valid` after g+2 rising edges counted from the hit edge. A walk over n entries with no match keeps `walk_busy` high for ceil(n/BANKS) cycles.
- R7: While `walk_busy` is high, a head entry that the walk has not yet checked cannot commit, and a filter hit is ignored. It neither restarts the walk nor lengthens it.
- R8: A flush sets `tail_ptr` to `flush_ptr` and `fifo_count` to the distance from `head_ptr` to it. In that cycle dispatch stalls and commit is refused. A running walk is trimmed so that it never checks a flushed entry.
- R9: After reset the FIFO is empty, both pointers are 0, no walk is running, no squash is signalled, and with no dispatch valid no stall is signalled.
- R10: An entry that has not issued since its dispatch is never matched by a walk, even if its slot held the matching address before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | A load is presented for dispatch |
| disp_dep_pred | input | 1 | Prediction: 1 dependent, 0 independent |
| disp_tag | input | TAG_W | Tag of the dispatched load |
| aq_count | input | AQ_CW | Occupancy of the associative queue |
| disp_to_fifo | output | 1 | Load is allocated in the FIFO |
| disp_to_assoc | output | 1 | Load is allocated in the associative queue |
| disp_stall | output | 1 | Dispatch must stall |
| disp_slot | output | PTR_W | FIFO pointer given to the load |
| iss_valid | input | 1 | A FIFO load issued |
| iss_slot | input | IDX_W | FIFO index of the issued load |
| iss_addr | input | ADDR_W | Address of the issued load |
| iss_data | input | DATA_W | Data returned to the issued load |
| cmt_valid | input | 1 | Request to retire the FIFO head |
| cmt_ok | output | 1 | Head retires this cycle |
| cmt_tag | output | TAG_W | Tag of the head entry |
| cmt_data | output | DATA_W | Data of the head entry |
| hit_valid | input | 1 | A committing store hit in the filter |
| hit_addr | input | ADDR_W | Address of that store |
| walk_busy | output | 1 | An ordered walk is in progress |
| squash_valid | output | 1 | Squash from the matching load onward |
| squash_tag | output | TAG_W | Tag of the matching load |
| flush_valid | input | 1 | Truncate the FIFO tail |
| flush_ptr | input | PTR_W | Pointer of the oldest flushed entry |
| head_ptr | output | PTR_W | FIFO head pointer |
| tail_ptr | output | PTR_W | FIFO tail pointer |
| fifo_count | output | CNT_W | Entries held in the FIFO |

## Verification
The hardest situations to set up are those where a walk overlaps other traffic: a commit that reaches the head exactly as the first bank group is checked, a second filter hit during a walk, and a flush landing between the walk's progress and a matching entry further on. The stimulus lines up FIFO contents with duplicate matching addresses in a later bank group, an unissued entry whose slot earlier held the hit address, and a flush pointer placed just before a match. Each event is timed to a chosen edge of the walk. It then samples `walk_busy`, `cmt_ok` and `squash_valid` cycle by cycle, against the group timing stated in R6.

// File: rtl/lqs_pkg.sv
package lqs_pkg;

    // Where the router sends the load presented this cycle
    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_FIFO  = 2'd1,
        TGT_ASSOC = 2'd2,
        TGT_STALL = 2'd3
    } lqs_tgt_e;

endpackage

// File: rtl/lqs_router.sv
module lqs_router
    import lqs_pkg::*;
#(
    parameter int DEPTH    = 48,
    parameter int AQ_DEPTH = 16,
    parameter int CNT_W    = $clog2(DEPTH + 1),
    parameter int AQ_CW    = $clog2(AQ_DEPTH + 1)
) (
    input  logic             disp_valid,
    input  logic             dep_pred,
    input  logic             flush_valid,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic [AQ_CW-1:0] aq_count,
    output lqs_tgt_e         tgt
);

    logic fifo_full;
    logic aq_full;

    assign fifo_full = (fifo_count >= CNT_W'(DEPTH));
    assign aq_full   = (aq_count >= AQ_CW'(AQ_DEPTH));

    // Independent loads spill into the associative queue.
    // Dependent loads wait for it.
    always_comb begin
        tgt = TGT_NONE;
        if (disp_valid) begin
            if (flush_valid) begin
                tgt = TGT_STALL;
            end else if (!dep_pred) begin
                if (!fifo_full)    tgt = TGT_FIFO;
                else if (!aq_full) tgt = TGT_ASSOC;
                else               tgt = TGT_STALL;
            end else begin
                tgt = aq_full ? TGT_STALL : TGT_ASSOC;
            end
        end
    end

endmodule

// File: rtl/lqs_store.sv
module lqs_store #(
    parameter int DEPTH  = 48,
    parameter int BANKS  = 4,
    parameter int TAG_W  = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic [IDX_W-1:0]  alloc_idx,
    input  logic [TAG_W-1:0]  alloc_tag,
    input  logic              iss_en,
    input  logic [IDX_W-1:0]  iss_idx,
    input  logic [ADDR_W-1:0] iss_addr,
    input  logic [DATA_W-1:0] iss_data,
    input  logic [IDX_W-1:0]  head_idx,
    output logic [TAG_W-1:0]  head_tag,
    output logic [DATA_W-1:0] head_data,
    output logic              head_issued,
    input  logic [IDX_W-1:0]  walk_base,
    output logic [TAG_W-1:0]  rd_tag    [BANKS],
    output logic [ADDR_W-1:0] rd_addr   [BANKS],
    output logic              rd_issued [BANKS]
);

    typedef struct {
        logic [TAG_W-1:0]  tag    [DEPTH];
        logic [ADDR_W-1:0] addr   [DEPTH];
        logic [DATA_W-1:0] data   [DEPTH];
        logic              issued [DEPTH];
    } store_t;

    store_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (alloc_en) begin
            st_d.tag[alloc_idx]    = alloc_tag;
            st_d.issued[alloc_idx] = 1'b0;
        end
        if (iss_en) begin
            st_d.addr[iss_idx]   = iss_addr;
            st_d.data[iss_idx]   = iss_data;
            st_d.issued[iss_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                st_q.tag[i]    <= '0;
                st_q.addr[i]   <= '0;
                st_q.data[i]   <= '0;
                st_q.issued[i] <= 1'b0;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign head_tag    = st_q.tag[head_idx];
    assign head_data   = st_q.data[head_idx];
    assign head_issued = st_q.issued[head_idx];

    // One read per bank: BANKS consecutive slots never share a bank
    for (genvar b = 0; b < BANKS; b++) begin : g_bank_rd
        logic [IDX_W:0]   sum;
        logic [IDX_W-1:0] ridx;
        assign sum  = {1'b0, walk_base} + (IDX_W+1)'(b);
        assign ridx = (sum >= (IDX_W+1)'(DEPTH)) ?
                      IDX_W'(sum - (IDX_W+1)'(DEPTH)) : sum[IDX_W-1:0];
        assign rd_tag[b]    = st_q.tag[ridx];
        assign rd_addr[b]   = st_q.addr[ridx];
        assign rd_issued[b] = st_q.issued[ridx];
    end

endmodule

// File: rtl/lqs_ctrl.sv
module lqs_ctrl #(
    parameter int DEPTH  = 48,
    parameter int BANKS  = 4,
    parameter int TAG_W  = 8,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = $clog2(DEPTH),
    parameter int PTR_W  = IDX_W + 1,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              cmt_valid,
    input  logic              head_issued,
    input  logic              hit_valid,
    input  logic [ADDR_W-1:0] hit_addr,
    input  logic              flush_valid,
    input  logic [PTR_W-1:0]  flush_ptr,
    input  logic [TAG_W-1:0]  rd_tag    [BANKS],
    input  logic [ADDR_W-1:0] rd_addr   [BANKS],
    input  logic              rd_issued [BANKS],
    output logic [PTR_W-1:0]  head_ptr,
    output logic [PTR_W-1:0]  tail_ptr,
    output logic [CNT_W-1:0]  count,
    output logic              cmt_ok,
    output logic              walk_busy,
    output logic [IDX_W-1:0]  walk_base,
    output logic              squash_valid,
    output logic [TAG_W-1:0]  squash_tag
);

    typedef struct packed {
        logic [PTR_W-1:0]  head;
        logic [PTR_W-1:0]  tail;
        logic [CNT_W-1:0]  count;
        logic              busy;
        logic [IDX_W-1:0]  wptr;   // next slot to check
        logic [CNT_W-1:0]  left;   // entries still to check
        logic [CNT_W-1:0]  chk;    // checked, not yet committed
        logic [ADDR_W-1:0] waddr;
        logic              sq_v;
        logic [TAG_W-1:0]  sq_tag;
    } ctrl_t;

    ctrl_t q, d;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        if (p[IDX_W-1:0] == IDX_W'(DEPTH - 1))
            return {~p[PTR_W-1], {IDX_W{1'b0}}};
        return {p[PTR_W-1], p[IDX_W-1:0] + 1'b1};
    endfunction

    function automatic logic [CNT_W-1:0] ptr_dist(input logic [PTR_W-1:0] a,
                                                  input logic [PTR_W-1:0] b);
        if (a[PTR_W-1] == b[PTR_W-1])
            return CNT_W'(b[IDX_W-1:0]) - CNT_W'(a[IDX_W-1:0]);
        return CNT_W'(DEPTH) - CNT_W'(a[IDX_W-1:0]) + CNT_W'(b[IDX_W-1:0]);
    endfunction

    logic             found;
    logic [TAG_W-1:0] found_tag;
    logic [CNT_W-1:0] nstep;
    logic [IDX_W:0]   wsum;
    logic [CNT_W-1:0] fdist;
    logic [CNT_W-1:0] frem;
    logic [PTR_W-1:0] head_nx;

    assign cmt_ok = cmt_valid && !flush_valid && (q.count != '0) && head_issued &&
                    (!q.busy || (q.chk != '0));

    // Oldest matching issued entry within the current bank group
    always_comb begin
        found     = 1'b0;
        found_tag = '0;
        for (int k = BANKS - 1; k >= 0; k--) begin
            if ((CNT_W'(k) < q.left) && rd_issued[k] && (rd_addr[k] == q.waddr)) begin
                found     = 1'b1;
                found_tag = rd_tag[k];
            end
        end
    end

    assign nstep   = (q.left > CNT_W'(BANKS)) ? CNT_W'(BANKS) : q.left;
    assign wsum    = {1'b0, q.wptr} + (IDX_W+1)'(nstep);
    assign fdist   = ptr_dist(q.head, flush_ptr);
    assign frem    = (fdist > q.chk) ? (fdist - q.chk) : '0;
    assign head_nx = cmt_ok ? ptr_inc(q.head) : q.head;

    always_comb begin
        d      = q;
        d.sq_v = 1'b0;
        if (flush_valid) begin
            d.tail  = flush_ptr;
            d.count = fdist;
            if (q.busy) begin
                d.chk  = (q.chk < fdist) ? q.chk : fdist;
                d.left = (q.left < frem) ? q.left : frem;
                if (d.left == '0) begin
                    d.busy = 1'b0;
                    d.chk  = '0;
                end
            end
        end else begin
            if (push) d.tail = ptr_inc(q.tail);
            d.head  = head_nx;
            d.count = q.count + CNT_W'(push) - CNT_W'(cmt_ok);
            if (q.busy) begin
                if (found) begin
                    d.sq_v   = 1'b1;
                    d.sq_tag = found_tag;
                    d.busy   = 1'b0;
                    d.left   = '0;
                    d.chk    = '0;
                end else begin
                    d.wptr = (wsum >= (IDX_W+1)'(DEPTH)) ?
                             IDX_W'(wsum - (IDX_W+1)'(DEPTH)) : wsum[IDX_W-1:0];
                    d.left = q.left - nstep;
                    d.chk  = q.chk + nstep - CNT_W'(cmt_ok);
                    if (d.left == '0) begin
                        d.busy = 1'b0;
                        d.chk  = '0;
                    end
                end
            end else if (hit_valid && ((q.count - CNT_W'(cmt_ok)) != '0)) begin
                d.busy  = 1'b1;
                d.waddr = hit_addr;
                d.wptr  = head_nx[IDX_W-1:0];
                d.left  = q.count - CNT_W'(cmt_ok);
                d.chk   = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign head_ptr     = q.head;
    assign tail_ptr     = q.tail;
    assign count        = q.count;
    assign walk_busy    = q.busy;
    assign walk_base    = q.wptr;
    assign squash_valid = q.sq_v;
    assign squash_tag   = q.sq_tag;

    // R1
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.count <= CNT_W'(DEPTH));

    // R7
    walk_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> ({1'b0, q.count} >= ({1'b0, q.chk} + {1'b0, q.left})));

    // R7
    walk_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> $past(hit_valid));

    // R5
    squash_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.sq_v |-> $past(q.busy));

    // R5
    squash_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.sq_v |=> !q.sq_v);

    // R8
    flush_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> (q.tail == $past(flush_ptr)));

endmodule

// File: rtl/split_lq_steer.sv
module split_lq_steer
    import lqs_pkg::*;
#(
    parameter int DEPTH    = 48,
    parameter int BANKS    = 4,
    parameter int TAG_W    = 8,
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int AQ_DEPTH = 16,
    parameter int IDX_W    = $clog2(DEPTH),
    parameter int PTR_W    = IDX_W + 1,
    parameter int CNT_W    = $clog2(DEPTH + 1),
    parameter int AQ_CW    = $clog2(AQ_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_valid,
    input  logic              disp_dep_pred,
    input  logic [TAG_W-1:0]  disp_tag,
    input  logic [AQ_CW-1:0]  aq_count,
    output logic              disp_to_fifo,
    output logic              disp_to_assoc,
    output logic              disp_stall,
    output logic [PTR_W-1:0]  disp_slot,
    input  logic              iss_valid,
    input  logic [IDX_W-1:0]  iss_slot,
    input  logic [ADDR_W-1:0] iss_addr,
    input  logic [DATA_W-1:0] iss_data,
    input  logic              cmt_valid,
    output logic              cmt_ok,
    output logic [TAG_W-1:0]  cmt_tag,
    output logic [DATA_W-1:0] cmt_data,
    input  logic              hit_valid,
    input  logic [ADDR_W-1:0] hit_addr,
    output logic              walk_busy,
    output logic              squash_valid,
    output logic [TAG_W-1:0]  squash_tag,
    input  logic              flush_valid,
    input  logic [PTR_W-1:0]  flush_ptr,
    output logic [PTR_W-1:0]  head_ptr,
    output logic [PTR_W-1:0]  tail_ptr,
    output logic [CNT_W-1:0]  fifo_count
);

    lqs_tgt_e          tgt;
    logic              head_issued;
    logic [IDX_W-1:0]  walk_base;
    logic [TAG_W-1:0]  rd_tag    [BANKS];
    logic [ADDR_W-1:0] rd_addr   [BANKS];
    logic              rd_issued [BANKS];

    lqs_router #(
        .DEPTH(DEPTH), .AQ_DEPTH(AQ_DEPTH), .CNT_W(CNT_W), .AQ_CW(AQ_CW)
    ) router_i (
        .disp_valid (disp_valid),
        .dep_pred   (disp_dep_pred),
        .flush_valid(flush_valid),
        .fifo_count (fifo_count),
        .aq_count   (aq_count),
        .tgt        (tgt)
    );

    assign disp_to_fifo  = (tgt == TGT_FIFO);
    assign disp_to_assoc = (tgt == TGT_ASSOC);
    assign disp_stall    = (tgt == TGT_STALL);
    assign disp_slot     = tail_ptr;

    lqs_store #(
        .DEPTH(DEPTH), .BANKS(BANKS), .TAG_W(TAG_W),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
    ) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (disp_to_fifo),
        .alloc_idx  (tail_ptr[IDX_W-1:0]),
        .alloc_tag  (disp_tag),
        .iss_en     (iss_valid),
        .iss_idx    (iss_slot),
        .iss_addr   (iss_addr),
        .iss_data   (iss_data),
        .head_idx   (head_ptr[IDX_W-1:0]),
        .head_tag   (cmt_tag),
        .head_data  (cmt_data),
        .head_issued(head_issued),
        .walk_base  (walk_base),
        .rd_tag     (rd_tag),
        .rd_addr    (rd_addr),
        .rd_issued  (rd_issued)
    );

    lqs_ctrl #(
        .DEPTH(DEPTH), .BANKS(BANKS), .TAG_W(TAG_W), .ADDR_W(ADDR_W),
        .IDX_W(IDX_W), .PTR_W(PTR_W), .CNT_W(CNT_W)
    ) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .push        (disp_to_fifo),
        .cmt_valid   (cmt_valid),
        .head_issued (head_issued),
        .hit_valid   (hit_valid),
        .hit_addr    (hit_addr),
        .flush_valid (flush_valid),
        .flush_ptr   (flush_ptr),
        .rd_tag      (rd_tag),
        .rd_addr     (rd_addr),
        .rd_issued   (rd_issued),
        .head_ptr    (head_ptr),
        .tail_ptr    (tail_ptr),
        .count       (fifo_count),
        .cmt_ok      (cmt_ok),
        .walk_busy   (walk_busy),
        .walk_base   (walk_base),
        .squash_valid(squash_valid),
        .squash_tag  (squash_tag)
    );

    // R2
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({disp_to_fifo, disp_to_assoc, disp_stall}));

    // R3
    dep_no_fifo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_dep_pred) |-> !disp_to_fifo);

    // R1
    full_no_fifo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_to_fifo |-> (fifo_count < CNT_W'(DEPTH)));

endmodule

// File: tb/split_lq_steer_tb_top.sv
`timescale 1ns/100ps
module split_lq_steer_tb_top;

    localparam int TAG_W = 8;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        disp_valid = 1'b0, disp_dep_pred = 1'b0;
    logic [7:0]  disp_tag = '0;
    logic [4:0]  aq_count = '0;
    logic        disp_to_fifo, disp_to_assoc, disp_stall;
    logic [6:0]  disp_slot;
    logic        iss_valid = 1'b0;
    logic [5:0]  iss_slot = '0;
    logic [31:0] iss_addr = '0, iss_data = '0;
    logic        cmt_valid = 1'b0, cmt_ok;
    logic [7:0]  cmt_tag;
    logic [31:0] cmt_data;
    logic        hit_valid = 1'b0;
    logic [31:0] hit_addr = '0;
    logic        walk_busy, squash_valid;
    logic [7:0]  squash_tag;
    logic        flush_valid = 1'b0;
    logic [6:0]  flush_ptr = '0;
    logic [6:0]  head_ptr, tail_ptr;
    logic [5:0]  fifo_count;

    int n_checks = 0;
    int n_fail = 0;

    typedef struct packed { logic [7:0] tag; logic [31:0] data; } item_t;
    item_t exp_q[$];

    always #2.5 clk = ~clk;

    split_lq_steer dut_i (.*);

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    endtask

    // Scoreboard monitor: each retired head must match the oldest expected item (R4)
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && cmt_ok) begin
                if (exp_q.size() == 0) begin
                    chk("R4", "commit with empty scoreboard", 1, 0);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    chk("R4", "commit tag", cmt_tag, it.tag);
                    chk("R4", "commit data", cmt_data, it.data);
                end
            end
        end
    end

    task automatic disp(logic dep, logic [7:0] tag, logic [4:0] aq,
                        logic ef, logic ea, logic es, logic [6:0] eslot, string req);
        @(negedge clk);
        disp_valid = 1'b1; disp_dep_pred = dep; disp_tag = tag; aq_count = aq;
        #2;
        chk(req, "to_fifo", disp_to_fifo, ef);
        chk(req, "to_assoc", disp_to_assoc, ea);
        chk(req, "stall", disp_stall, es);
        if (ef) begin
            chk(req, "slot", disp_slot, eslot);
            exp_q.push_back({tag, 32'hD000 + 32'(tag)});
        end
        @(posedge clk); #1;
        disp_valid = 1'b0;
    endtask

    task automatic issue(logic [5:0] slot, logic [31:0] addr, logic [7:0] tag);
        @(negedge clk);
        iss_valid = 1'b1; iss_slot = slot; iss_addr = addr; iss_data = 32'hD000 + 32'(tag);
        @(posedge clk); #1;
        iss_valid = 1'b0;
    endtask

    task automatic cmt(logic eok, string req);
        @(negedge clk);
        cmt_valid = 1'b1;
        #2;
        chk(req, "cmt_ok", cmt_ok, eok);
        @(posedge clk); #1;
        cmt_valid = 1'b0;
    endtask

    task automatic flush(logic [6:0] p, int npop, logic with_disp);
        @(negedge clk);
        flush_valid = 1'b1; flush_ptr = p;
        if (with_disp) begin
            disp_valid = 1'b1; disp_dep_pred = 1'b0; disp_tag = 8'hEE; aq_count = '0;
        end
        #2;
        if (with_disp) chk("R8", "stall during flush", disp_stall, 1);
        @(posedge clk); #1;
        flush_valid = 1'b0; disp_valid = 1'b0;
        for (int i = 0; i < npop; i++) void'(exp_q.pop_back());
    endtask

    // One cycle with an optional filter hit; samples walk state between edges
    task automatic cyc(logic hv, logic [31:0] ha, logic eb, logic es,
                       logic [7:0] etag, string req);
        @(negedge clk);
        hit_valid = hv; hit_addr = ha;
        #2;
        chk(req, "walk_busy", walk_busy, eb);
        chk(req, "squash_valid", squash_valid, es);
        if (es) chk(req, "squash_tag", squash_tag, etag);
        @(posedge clk); #1;
        hit_valid = 1'b0;
    endtask

    initial begin
        #1ms;
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R9 reset state
        @(negedge clk); #2;
        chk("R9", "fifo_count", fifo_count, 0);
        chk("R9", "head_ptr", head_ptr, 0);
        chk("R9", "tail_ptr", tail_ptr, 0);
        chk("R9", "walk_busy", walk_busy, 0);
        chk("R9", "squash_valid", squash_valid, 0);
        chk("R9", "stall idle", disp_stall, 0);

        // R1 independent loads fill the FIFO in order
        disp(0, 8'd10, 5'd0, 1, 0, 0, 7'd0, "R1");
        disp(0, 8'd11, 5'd0, 1, 0, 0, 7'd1, "R1");
        disp(0, 8'd12, 5'd0, 1, 0, 0, 7'd2, "R1");
        chk("R1", "count after 3", fifo_count, 3);
        chk("R1", "tail after 3", tail_ptr, 3);

        // R3 dependent loads: associative queue, or stall when it is full
        disp(1, 8'd20, 5'd3, 0, 1, 0, 7'd0, "R3");
        disp(1, 8'd21, 5'd16, 0, 0, 1, 7'd0, "R3");
        chk("R3", "count unchanged", fifo_count, 3);

        // R4 in-order commit, only of issued heads
        issue(6'd0, 32'h100, 8'd10);
        issue(6'd1, 32'h101, 8'd11);
        issue(6'd2, 32'h102, 8'd12);
        cmt(1, "R4"); cmt(1, "R4"); cmt(1, "R4");
        disp(0, 8'd13, 5'd0, 1, 0, 0, 7'd3, "R1");
        cmt(0, "R4");

        // R8 flush everything with a dispatch in the same cycle
        flush(7'd3, 1, 1);
        chk("R8", "count after flush", fifo_count, 0);
        chk("R8", "tail after flush", tail_ptr, 3);

        // R10 setup: slot 3 issues 0x777, is flushed, then redispatched unissued
        disp(0, 8'd30, 5'd0, 1, 0, 0, 7'd3, "R1");
        issue(6'd3, 32'h777, 8'd30);
        flush(7'd3, 1, 0);
        disp(0, 8'd30, 5'd0, 1, 0, 0, 7'd3, "R1");
        for (int k = 1; k < 10; k++) begin
            disp(0, 8'(30 + k), 5'd0, 1, 0, 0, 7'(3 + k), "R1");
            issue(6'(3 + k), (k == 6 || k == 9) ? 32'h300 : 32'h200 + 32'(k), 8'(30 + k));
        end
        chk("R1", "count 10", fifo_count, 10);

        // Walk A: no match over 10 entries, 3 walk cycles; second hit ignored (R6, R7, R10)
        cyc(1, 32'h777, 0, 0, 0, "R10");
        cyc(0, 0,       1, 0, 0, "R6");
        cyc(1, 32'h300, 1, 0, 0, "R7");
        cyc(0, 0,       1, 0, 0, "R6");
        cyc(0, 0,       0, 0, 0, "R7");
        cyc(0, 0,       0, 0, 0, "R10");

        // Walk B: match in group 1 at slot 9, duplicate at slot 12 (R5, R6)
        cyc(1, 32'h300, 0, 0, 0,     "R5");
        cyc(0, 0,       1, 0, 0,     "R6");
        cyc(0, 0,       1, 0, 0,     "R6");
        cyc(0, 0,       0, 1, 8'd36, "R5");
        cyc(0, 0,       0, 0, 0,     "R5");

        // Walk C: commit blocked until the head is checked (R7)
        issue(6'd3, 32'h200, 8'd30);
        cyc(1, 32'h5555, 0, 0, 0, "R7");
        cmt(0, "R7");
        cmt(1, "R7");
        cmt(1, "R7");
        cyc(0, 0, 0, 0, 0, "R7");

        // Walk D: flush before the matching slot 9 trims the walk (R8)
        cyc(1, 32'h300, 0, 0, 0, "R8");
        flush(7'd9, 4, 0);
        chk("R8", "count after trim", fifo_count, 4);
        chk("R8", "tail after trim", tail_ptr, 9);
        cyc(0, 0, 1, 0, 0, "R8");
        cyc(0, 0, 0, 0, 0, "R8");
        cyc(0, 0, 0, 0, 0, "R8");
        cmt(1, "R4"); cmt(1, "R4"); cmt(1, "R4"); cmt(1, "R4");
        chk("R4", "empty after commits", fifo_count, 0);
        chk("R4", "head after commits", head_ptr, 9);

        // R1/R2 fill across the wrap, then overflow behaviour
        for (int i = 0; i < 48; i++) begin
            int s;
            s = 9 + i;
            disp(0, 8'(100 + i), 5'd0, 1, 0, 0,
                 (s >= 48) ? {1'b1, 6'(s - 48)} : {1'b0, 6'(s)}, "R1");
        end
        chk("R2", "count full", fifo_count, 48);
        disp(0, 8'd200, 5'd5,  0, 1, 0, 7'd0, "R2");
        disp(0, 8'd201, 5'd16, 0, 0, 1, 7'd0, "R2");
        disp(1, 8'd202, 5'd3,  0, 1, 0, 7'd0, "R3");
        chk("R2", "count still full", fifo_count, 48);
        flush(7'd9, 48, 0);
        chk("R8", "count after full flush", fifo_count, 0);

        repeat (2) @(negedge clk);
        chk("R4", "scoreboard drained", exp_q.size(), 0);
        summary();
        $finish;
    end

endmodule